// File: doc/BRIEF.md
# SPI Command Sequencer for a Memory-Mapping Peripheral

This block sits on the host side of a shared SPI bus. It turns one request from a valid/ready interface into one framed SPI command for a memory-mapping peripheral. The request can be an address load, a memory-size code, a mapping-mode code, a single-byte read or a single-byte write. A storage card owns the bus while the sequencer is idle. For each request the sequencer releases the card select, asserts the peripheral select, clocks the frame out most significant bit first, and then hands the bus back to the card.

SCK comes from a programmable divider of the system clock. The frame is padded at both ends with a quiet interval of one SCK period. For a read, the byte sampled on MISO during the data slot is returned on `rdata` together with a single-cycle `done` pulse. Every request, whatever its kind, ends with that pulse.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: After reset, `card_cs_n` is 0, `periph_cs_n` is 1, `sck` is 0, `req_ready` is 1 and `done` is 0.
- R2: The two selects are never low in the same cycle. `card_cs_n` is high in the cycle before `periph_cs_n` falls, and `periph_cs_n` is high in the cycle before `card_cs_n` falls again.
- R3: Request code 0 sends four bytes: 0x00, then address bits 23:16, then 15:8, then 7:0.
- R4: Request code 1 sends the single byte 0x2s, where s is `req_imm`.
- R5: Request code 2 sends the single byte 0x3m, where m is `req_imm` (0 selects the high-ROM layout, 1 the low-ROM layout).
- R6: Request code 3 sends opcode 0x80 when `req_incr` is 1 or 0x81 when it is 0, followed by 0x00. MISO is sampled at each rising SCK edge. The eight bits of the second byte, MSB first, appear on `rdata` while `done` is high; the opcode-slot bits do not.
- R7: Request code 4 sends opcode 0x90 when `req_incr` is 1 or 0x91 when it is 0, followed by `req_wdata`.
- R8: SCK idles low while the peripheral is deselected. Each SCK level lasts exactly max(`half_div`, 2) system clocks. MOSI changes only while SCK is low, and bits go out MSB first.
- R9: At least one SCK period (two half-periods) passes between the fall of `periph_cs_n` and the first rising SCK edge. At least one SCK period also passes between the last falling SCK edge and the rise of `periph_cs_n`.
- R10: `done` is a one-cycle pulse in the first idle cycle after a frame. `req_ready` is high only while idle. Request codes 5 to 7 complete with `done` on the cycle after acceptance, with no select or SCK activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | SCK half-period in system clocks; values below 2 are treated as 2 |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Request code: 0 address, 1 size, 2 mapping, 3 read, 4 write |
| req_addr | input | 24 | Address for code 0 |
| req_imm | input | 4 | Size or mapping code for codes 1 and 2 |
| req_incr | input | 1 | 1 selects the auto-increment opcode for codes 3 and 4 |
| req_wdata | input | 8 | Data byte for code 4 |
| req_ready | output | 1 | Sequencer idle and accepting |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| periph_cs_n | output | 1 | Peripheral select, active low |
| card_cs_n | output | 1 | Storage-card select, active low |

## Verification
The bench targets four kinds of error.

The first is the select handover. A design that switched both selects in the same cycle would briefly show both low, or neither gap cycle.

The second is divider clamping at `half_div` values of 0 and 1. A design without the clamp would produce one-cycle SCK levels, or stall because its divider could never match.

The third is the read data slot. The bench's slave drives the inverted pattern during the opcode slot, so a design that latched the wrong byte returns a visibly wrong value.

The fourth is opcode framing. All sixteen size codes, both mapping codes and both increment polarities are swept, so a flipped increment bit or a swapped nibble shows up in the captured MOSI stream.

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  input  logic [23:0]      req_addr,
  input  logic [3:0]       req_imm,
  input  logic             req_incr,
  input  logic [7:0]       req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [7:0]       rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             periph_cs_n,
  output logic             card_cs_n
);

  localparam int FRAME_W = 32;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_HAND, S_LEAD, S_SHIFT, S_TRAIL, S_REL} st_t;

  st_t                state;
  logic [DIV_W-1:0]   div_cnt;
  logic               ph;
  logic [FRAME_W-1:0] sh;
  logic [BCNT_W-1:0]  nbits, bitcnt;
  logic [7:0]         rx;
  logic               is_rd;

  wire [DIV_W-1:0] half_eff = (half_div < DIV_W'(2)) ? DIV_W'(2) : half_div;
  wire             tick     = (div_cnt == half_eff - DIV_W'(1));
  wire             gap_busy = (state == S_LEAD) || (state == S_TRAIL);

  assign req_ready   = (state == S_IDLE);
  assign card_cs_n   = (state != S_IDLE);
  assign periph_cs_n = !(gap_busy || state == S_SHIFT);
  assign mosi        = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      div_cnt <= '0;
      ph      <= 1'b0;
      sck     <= 1'b0;
      sh      <= '0;
      nbits   <= '0;
      bitcnt  <= '0;
      rx      <= '0;
      rdata   <= '0;
      is_rd   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          div_cnt <= '0;
          bitcnt  <= '0;
          if (req_valid) begin
            is_rd <= (req_cmd == 3'd3);
            state <= S_HAND;
            case (req_cmd)
              3'd0: begin sh <= {8'h00, req_addr};                           nbits <= BCNT_W'(32); end
              3'd1: begin sh <= {4'h2, req_imm, 24'h0};                      nbits <= BCNT_W'(8);  end
              3'd2: begin sh <= {4'h3, req_imm, 24'h0};                      nbits <= BCNT_W'(8);  end
              3'd3: begin sh <= {7'b1000000, ~req_incr, 8'h00, 16'h0};       nbits <= BCNT_W'(16); end
              3'd4: begin sh <= {7'b1001000, ~req_incr, req_wdata, 16'h0};   nbits <= BCNT_W'(16); end
              default: begin
                state <= S_IDLE;
                done  <= 1'b1;
              end
            endcase
          end
        end
        S_HAND: begin
          div_cnt <= '0;
          ph      <= 1'b0;
          state   <= S_LEAD;
        end
        S_LEAD, S_TRAIL: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick) begin
            ph <= ~ph;
            if (ph) state <= (state == S_LEAD) ? S_SHIFT : S_REL;
          end
        end
        S_SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
              rx  <= {rx[6:0], miso};
            end else begin
              sck    <= 1'b0;
              sh     <= sh << 1;
              bitcnt <= bitcnt + BCNT_W'(1);
              if (bitcnt == nbits - BCNT_W'(1)) begin
                state <= S_TRAIL;
                ph    <= 1'b0;
              end
            end
          end
        end
        S_REL: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (is_rd) rdata <= rx;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_sequencer_sva.sv
module spi_cmd_sequencer_sva (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic sck,
  input logic mosi,
  input logic periph_cs_n,
  input logic card_cs_n
);

  p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!periph_cs_n && !card_cs_n));

  p_card_off_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_cs_n) |-> $past(card_cs_n));

  p_periph_off_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_cs_n) |-> $past(periph_cs_n));

  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_cs_n |-> !sck);

  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  p_sck_min_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |=> $stable(sck));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && periph_cs_n));

  p_ready_card_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!card_cs_n && periph_cs_n));

endmodule

bind spi_cmd_sequencer spi_cmd_sequencer_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .sck(sck),
  .mosi(mosi), .periph_cs_n(periph_cs_n), .card_cs_n(card_cs_n)
);

// File: tb/spi_cmd_sequencer_tb.sv
module spi_cmd_sequencer_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] half_div = 8'd2;
  logic req_valid = 0, req_incr = 0;
  logic [2:0] req_cmd = 0;
  logic [23:0] req_addr = 0;
  logic [3:0] req_imm = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, done, sck, mosi, miso, periph_cs_n, card_cs_n;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  spi_cmd_sequencer #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_imm(req_imm), .req_incr(req_incr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .periph_cs_n(periph_cs_n), .card_cs_n(card_cs_n)
  );

  int nchk = 0, nfail = 0;
  int hexp = 2;
  logic [7:0] rd_pat = 8'h00;

  // bus monitor and slave model, evaluated on falling clock edges
  logic [31:0] cap = 0;
  int nb = 0, frames = 0, lead = 0, edge_cnt = 0, since_fall = 0;
  bit in_lead = 0;
  int e_ovl = 0, e_hand = 0, e_half = 0, e_lead = 0, e_trail = 0, e_mosi = 0, e_idle = 0;
  logic p_sck = 0, p_per = 1, p_card = 0, p_mosi = 0;

  assign miso = (nb >= 8 && nb < 16) ? rd_pat[15 - nb] : ~rd_pat[(nb < 8) ? 7 - nb : 0];

  always @(negedge clk) begin
    if (rst_n) begin
      edge_cnt++;
      since_fall++;
      if (!periph_cs_n && !card_cs_n) e_ovl++;
      if (p_per && !periph_cs_n) begin
        if (!p_card) e_hand++;
        frames++; cap = 0; nb = 0; lead = 0; in_lead = 1;
      end else if (in_lead) lead++;
      if (p_card && !card_cs_n && !p_per) e_hand++;
      if (!p_per && periph_cs_n) begin
        if (!card_cs_n) e_hand++;
        if (since_fall < 2 * hexp) e_trail++;
      end
      if (periph_cs_n && sck) e_idle++;
      if (sck && p_sck && mosi !== p_mosi) e_mosi++;
      if (sck != p_sck) begin
        if (!(sck && nb == 0) && edge_cnt != hexp) e_half++;
        edge_cnt = 0;
        if (sck) begin
          cap = {cap[30:0], mosi};
          nb++;
          if (in_lead) begin
            if (lead < 2 * hexp) e_lead++;
            in_lead = 0;
          end
        end else since_fall = 0;
      end
      p_sck = sck; p_per = periph_cs_n; p_card = card_cs_n; p_mosi = mosi;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] cmd, input logic [23:0] a, input logic [3:0] imm,
                         input logic inc, input logic [7:0] wd, input logic [31:0] exp_bits,
                         input int exp_n, input string rq);
    int f0, t0;
    f0 = frames;
    t0 = e_ovl + e_hand + e_half + e_lead + e_trail + e_mosi + e_idle;
    @(negedge clk);
    chk(req_ready === 1'b1, "R10 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_cmd = cmd; req_addr = a; req_imm = imm; req_incr = inc; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (exp_n > 0) chk(req_ready === 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
    while (done !== 1'b1) @(negedge clk);
    if (exp_n == 0) begin
      chk(frames == f0, "R10 reserved code makes no frame", frames - f0, 0);
    end else begin
      chk(frames == f0 + 1, {rq, " one frame"}, frames - f0, 1);
      chk(nb == exp_n, {rq, " bit count"}, nb, exp_n);
      chk(cap == exp_bits, {rq, " frame bits"}, cap, exp_bits);
      chk(e_ovl + e_hand == 0, "R2 select handover", e_ovl + e_hand, 0);
      chk(e_half + e_mosi + e_idle == 0, "R8 sck timing/mosi", e_half + e_mosi + e_idle, 0);
      chk(e_lead + e_trail + e_ovl + e_hand + e_half + e_mosi + e_idle == t0,
          "R9 select-to-clock gaps", e_lead + e_trail, 0);
      if (cmd == 3'd3) chk(rdata == rd_pat, "R6 read data", rdata, rd_pat);
    end
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [23:0] addrs [3];
    addrs[0] = 24'hA5C31E; addrs[1] = 24'h000001; addrs[2] = 24'hFFFFFE;
    repeat (3) @(negedge clk);
    chk(card_cs_n === 1'b0 && periph_cs_n === 1'b1, "R1 reset selects", {card_cs_n, periph_cs_n}, 2'b01);
    chk(sck === 1'b0 && done === 1'b0, "R1 reset sck/done", {sck, done}, 0);
    chk(req_ready === 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1;
    foreach (addrs[i]) ;
    for (int hd = 0; hd < 8; hd++) begin
      if (hd == 5 || hd == 6) continue;
      half_div = 8'(hd);
      hexp = (hd < 2) ? 2 : hd;
      for (int i = 0; i < 3; i++)
        run_req(3'd0, addrs[i], 4'h0, 0, 8'h00, {8'h00, addrs[i]}, 32, "R3 address");
      for (int s = 0; s < 16; s++)
        run_req(3'd1, 24'h0, 4'(s), 0, 8'h00, {24'h0, 4'h2, 4'(s)}, 8, "R4 size");
      for (int m = 0; m < 2; m++)
        run_req(3'd2, 24'h0, 4'(m), 0, 8'h00, {24'h0, 4'h3, 4'(m)}, 8, "R5 mapping");
      for (int k = 0; k < 4; k++) begin
        rd_pat = 8'(8'h3C + 8'(37 * k + hd));
        run_req(3'd3, 24'h0, 4'h0, k[0], 8'h00, {16'h0, 7'b1000000, ~k[0], 8'h00}, 16, "R6 read");
      end
      for (int k = 0; k < 4; k++) begin
        logic [7:0] wd;
        wd = 8'(8'hC5 ^ 8'(29 * k + hd));
        run_req(3'd4, 24'h0, 4'h0, k[0], wd, {16'h0, 7'b1001000, ~k[0], wd}, 16, "R7 write");
      end
      for (int c = 5; c < 8; c++)
        run_req(3'(c), 24'h0, 4'h0, 0, 8'h00, 32'h0, 0, "R10 reserved");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule